// File: doc/BRIEF.md
# Synchronous Burst Cycle Controller

This block sequences the cycles of a pipelined synchronous burst SRAM. On every rising clock edge it samples three chip enables, two address strobes (a processor strobe and a controller strobe), a burst-advance input, an order-select input and the write-control inputs. From these it issues one command per cycle to the storage array: a read, a write with per-lane strobes, or nothing. It also supplies the word address for that command and a data-drive enable that follows the one-cycle pipelined read latency.

A burst starts from an external address. It then walks the two low address bits in linear or interleaved order, or holds its place while wait cycles are inserted. The processor strobe always opens a read. A write after a processor strobe is made by asserting the write inputs in the wait cycle that follows. The controller strobe opens either a read or a write, depending on the write inputs.

The cycle state machine has three states. CYC_IDLE means deselected, with no command. CYC_READ means the current cycle reads. CYC_WRITE means the current cycle writes. The transition chosen on each edge is one of six. ACT_DESEL goes to IDLE. ACT_HOLD stays IDLE. ACT_PSTART goes to READ with the external address. ACT_CSTART goes to READ or WRITE with the external address. ACT_ADVANCE goes to READ or WRITE at the next burst address. ACT_SUSPEND goes to READ or WRITE at the same address.

Top module: `burst_cycle_ctrl`

## Requirements
- R1: The chip counts as selected only when `pipe_en_n`=0, `depth_en`=1 and `depth_en_n`=0. An accepted strobe while the chip is not selected gives a deselect: in the next cycle `mem_rd`=0, `mem_wr`=0 and `mem_lane_we`=0.
- R2: With `pipe_en_n`=1, `proc_strobe_n` has no effect: the burst state and the outputs behave as if it were high. In that case `ctrl_strobe_n`=0 causes a deselect.
- R3: `proc_strobe_n`=0 while selected starts a read at `ext_addr` in the next cycle, whatever the write inputs are.
- R4: The cycle after a processor-strobe start, with both strobes high, `advance_n`=1 and the write condition asserted, is a write to the same address.
- R5: `ctrl_strobe_n`=0 with no accepted processor strobe, while selected, loads `ext_addr` and issues a write if the write condition holds, otherwise a read.
- R6: With both strobes high during an active burst, `advance_n`=0 moves to the next burst address. The command is write or read according to the write condition.
- R7: With both strobes high during an active burst, `advance_n`=1 keeps the current address and issues a wait cycle. The command is write or read according to the write condition.
- R8: Write condition: `global_wr_n`=0 sets all `mem_lane_we` bits. Otherwise, with `byte_wr_n`=0, bit i of `mem_lane_we` equals NOT `lane_wr_n[i]`. With `byte_wr_n`=1, or with no lane enabled, the cycle is a read and `mem_lane_we`=0.
- R9: With `interleave`=0, the low two bits of `mem_addr` are (start + n) mod 4 on the n-th advance. The upper bits stay fixed during the burst.
- R10: With `interleave`=1, the low two bits of `mem_addr` are start XOR (n mod 4).
- R11: `dq_drive`=1 exactly when the previous cycle was a read, `out_en_n`=0 and the current cycle is not a write. `out_en_n` acts without a clock.
- R12: After a deselect, a read issued just before it still drives for one more cycle. The drive is off in the cycle after that.
- R13: While deselected, with both strobes high, the block stays idle with no command. After reset all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pipe_en_n | input | 1 | Address-pipeline enable, active low |
| depth_en | input | 1 | Depth-expansion enable, active high |
| depth_en_n | input | 1 | Depth-expansion enable, active low |
| proc_strobe_n | input | 1 | Processor address strobe, active low |
| ctrl_strobe_n | input | 1 | Controller address strobe, active low |
| advance_n | input | 1 | Burst advance, active low |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| global_wr_n | input | 1 | Write-all-lanes request, active low |
| byte_wr_n | input | 1 | Lane-write qualifier, active low |
| lane_wr_n | input | LANES | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable, active low, asynchronous |
| ext_addr | input | ADDR_W | External word address |
| mem_addr | output | ADDR_W | Word address to the array |
| mem_rd | output | 1 | Read command for the current cycle |
| mem_wr | output | 1 | Write command for the current cycle |
| mem_lane_we | output | LANES | Per-lane write strobes |
| dq_drive | output | 1 | Enable for driving pipelined read data |

## Verification
Three pairs of functions can fall in the same cycle. A processor strobe can coincide with an asserted write condition; the strobe must win and give a read. A deselect can meet the pipelined read drive still pending from the cycle before. A write issued in a suspend cycle can land right after a read whose data would otherwise be driven. The bench provokes all of these with directed sequences. It also runs a long sweep in which every control input is drawn freely each cycle, so these collisions recur in many states. Each cycle is judged against a bench model of the burst state. The model recomputes the address arithmetically in both orders and derives the drive enable from the previous command and the current command.

// File: rtl/burst_ctrl_pkg.sv
package burst_ctrl_pkg;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'd0,
        CYC_READ  = 2'd1,
        CYC_WRITE = 2'd2
    } cyc_state_t;

    typedef enum logic [2:0] {
        ACT_HOLD    = 3'd0,
        ACT_DESEL   = 3'd1,
        ACT_PSTART  = 3'd2,
        ACT_CSTART  = 3'd3,
        ACT_ADVANCE = 3'd4,
        ACT_SUSPEND = 3'd5
    } cyc_action_t;

    localparam int unsigned BURST_BITS = 2;

    // Low address bits for a burst position in either order.
    function automatic logic [BURST_BITS-1:0] burst_offset(
        input logic [BURST_BITS-1:0] start,
        input logic [BURST_BITS-1:0] step,
        input logic                  xor_order
    );
        logic [BURST_BITS-1:0] res;
        if (xor_order) res = start ^ step;
        else           res = start + step;
        return res;
    endfunction

endpackage

// File: rtl/cycle_decode.sv
module cycle_decode
    import burst_ctrl_pkg::*;
#(
    parameter int unsigned LANES = 2
) (
    input  logic             pipe_en_n,
    input  logic             depth_en,
    input  logic             depth_en_n,
    input  logic             proc_strobe_n,
    input  logic             ctrl_strobe_n,
    input  logic             advance_n,
    input  logic             global_wr_n,
    input  logic             byte_wr_n,
    input  logic [LANES-1:0] lane_wr_n,
    input  cyc_state_t       cur_state,
    output cyc_action_t      action,
    output cyc_state_t       next_state,
    output logic [LANES-1:0] next_lanes
);

    logic             selected;
    logic             proc_taken;
    logic [LANES-1:0] req_lanes;
    logic             wr_req;

    assign selected   = !pipe_en_n && depth_en && !depth_en_n;
    assign proc_taken = !pipe_en_n && !proc_strobe_n;

    // Lane strobe generation: global write first, then qualified lanes.
    always_comb begin
        if (!global_wr_n)     req_lanes = {LANES{1'b1}};
        else if (!byte_wr_n)  req_lanes = ~lane_wr_n;
        else                  req_lanes = '0;
    end

    assign wr_req = |req_lanes;

    // Transition selection, in priority order.
    always_comb begin
        if (pipe_en_n && !ctrl_strobe_n)
            action = ACT_DESEL;
        else if (proc_taken)
            action = selected ? ACT_PSTART : ACT_DESEL;
        else if (!ctrl_strobe_n)
            action = selected ? ACT_CSTART : ACT_DESEL;
        else if (cur_state == CYC_IDLE)
            action = ACT_HOLD;
        else if (advance_n)
            action = ACT_SUSPEND;
        else
            action = ACT_ADVANCE;
    end

    always_comb begin
        next_state = CYC_IDLE;
        next_lanes = '0;
        unique case (action)
            ACT_HOLD, ACT_DESEL: begin
                next_state = CYC_IDLE;
            end
            ACT_PSTART: begin
                next_state = CYC_READ;
            end
            ACT_CSTART, ACT_ADVANCE, ACT_SUSPEND: begin
                next_state = wr_req ? CYC_WRITE : CYC_READ;
                next_lanes = wr_req ? req_lanes : '0;
            end
            default: begin
                next_state = CYC_IDLE;
            end
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cyc_action_t       action,
    input  logic [ADDR_W-1:0] ext_addr,
    input  logic              interleave,
    output logic [ADDR_W-1:0] mem_addr
);

    localparam int unsigned HI_W = ADDR_W - BURST_BITS;

    logic [HI_W-1:0]       hi_q;
    logic [BURST_BITS-1:0] start_q;
    logic [BURST_BITS-1:0] step_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            start_q <= '0;
            step_q  <= '0;
        end else begin
            unique case (action)
                ACT_PSTART, ACT_CSTART: begin
                    hi_q    <= ext_addr[ADDR_W-1:BURST_BITS];
                    start_q <= ext_addr[BURST_BITS-1:0];
                    step_q  <= '0;
                end
                ACT_ADVANCE: begin
                    step_q <= step_q + 1'b1;
                end
                default: begin
                    step_q <= step_q;
                end
            endcase
        end
    end

    assign mem_addr = {hi_q, burst_offset(start_q, step_q, interleave)};

    // R6
    step_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_ADVANCE) |=> (step_q == $past(step_q) + 1'b1) && $stable(hi_q))
        else $error("burst step did not advance");

    // R7
    suspend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (action == ACT_SUSPEND) |=> $stable(step_q) && $stable(start_q) && $stable(hi_q))
        else $error("burst position moved during suspend");

endmodule

// File: rtl/read_oe_pipe.sv
module read_oe_pipe
    import burst_ctrl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  cyc_state_t cur_state,
    input  logic       out_en_n,
    output logic       dq_drive
);

    logic rd_pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rd_pend_q <= 1'b0;
        else        rd_pend_q <= (cur_state == CYC_READ);
    end

    assign dq_drive = rd_pend_q && (cur_state != CYC_WRITE) && !out_en_n;

    // R12
    desel_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_state == CYC_IDLE) |=> !dq_drive)
        else $error("drive still on two cycles after deselect");

endmodule

// File: rtl/burst_cycle_ctrl.sv
module burst_cycle_ctrl
    import burst_ctrl_pkg::*;
#(
    parameter int unsigned ADDR_W = 10,
    parameter int unsigned LANES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pipe_en_n,
    input  logic              depth_en,
    input  logic              depth_en_n,
    input  logic              proc_strobe_n,
    input  logic              ctrl_strobe_n,
    input  logic              advance_n,
    input  logic              interleave,
    input  logic              global_wr_n,
    input  logic              byte_wr_n,
    input  logic [LANES-1:0]  lane_wr_n,
    input  logic              out_en_n,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic [LANES-1:0]  mem_lane_we,
    output logic              dq_drive
);

    cyc_state_t       state_q;
    cyc_state_t       state_d;
    cyc_action_t      action;
    logic [LANES-1:0] lanes_q;
    logic [LANES-1:0] lanes_d;

    cycle_decode #(.LANES(LANES)) u_decode (
        .pipe_en_n     (pipe_en_n),
        .depth_en      (depth_en),
        .depth_en_n    (depth_en_n),
        .proc_strobe_n (proc_strobe_n),
        .ctrl_strobe_n (ctrl_strobe_n),
        .advance_n     (advance_n),
        .global_wr_n   (global_wr_n),
        .byte_wr_n     (byte_wr_n),
        .lane_wr_n     (lane_wr_n),
        .cur_state     (state_q),
        .action        (action),
        .next_state    (state_d),
        .next_lanes    (lanes_d)
    );

    burst_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .action     (action),
        .ext_addr   (ext_addr),
        .interleave (interleave),
        .mem_addr   (mem_addr)
    );

    read_oe_pipe u_oe (
        .clk       (clk),
        .rst_n     (rst_n),
        .cur_state (state_q),
        .out_en_n  (out_en_n),
        .dq_drive  (dq_drive)
    );

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= CYC_IDLE;
            lanes_q <= '0;
        end else begin
            state_q <= state_d;
            lanes_q <= lanes_d;
        end
    end

    // Outputs from state.
    always_comb begin
        mem_rd      = 1'b0;
        mem_wr      = 1'b0;
        mem_lane_we = '0;
        unique case (state_q)
            CYC_IDLE: begin
            end
            CYC_READ: begin
                mem_rd = 1'b1;
            end
            CYC_WRITE: begin
                mem_wr      = 1'b1;
                mem_lane_we = lanes_q;
            end
            default: begin
            end
        endcase
    end

    // R1
    desel_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_strobe_n || (!pipe_en_n && !proc_strobe_n)) &&
        !(!pipe_en_n && depth_en && !depth_en_n)
        |=> !mem_rd && !mem_wr && (mem_lane_we == '0))
        else $error("command issued on deselect");

    // R3
    proc_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_en_n && depth_en && !depth_en_n && !proc_strobe_n
        |=> mem_rd && !mem_wr && (mem_addr == $past(ext_addr)))
        else $error("processor strobe did not start a read");

    // R8
    global_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pipe_en_n && depth_en && !depth_en_n && proc_strobe_n &&
        !ctrl_strobe_n && !global_wr_n
        |=> mem_wr && (&mem_lane_we))
        else $error("global write did not set all lanes");

    // R13
    cmd_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({mem_rd, mem_wr}))
        else $error("read and write together");

    // R8
    lanes_only_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_wr |-> (mem_lane_we == '0))
        else $error("lane strobes outside a write");

endmodule

// File: tb/test_burst_cycle_ctrl.sv
module test_burst_cycle_ctrl;

    localparam int ADDR_W = 10;
    localparam int LANES  = 2;
    localparam int HI_W   = ADDR_W - 2;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              pipe_en_n = 1'b1, depth_en = 1'b0, depth_en_n = 1'b1;
    logic              proc_strobe_n = 1'b1, ctrl_strobe_n = 1'b1, advance_n = 1'b1;
    logic              interleave = 1'b0, global_wr_n = 1'b1, byte_wr_n = 1'b1;
    logic [LANES-1:0]  lane_wr_n = '1;
    logic              out_en_n = 1'b1;
    logic [ADDR_W-1:0] ext_addr = '0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_rd, mem_wr, dq_drive;
    logic [LANES-1:0]  mem_lane_we;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // model state: kind 0 idle, 1 read, 2 write
    int              m_kind = 0;
    logic [HI_W-1:0] m_hi = '0;
    logic [1:0]      m_start = '0, m_step = '0;
    logic [LANES-1:0] m_lanes = '0;
    logic            m_rdp = 1'b0;
    string           m_tag = "R13";

    always #4 clk = ~clk;

    burst_cycle_ctrl #(.ADDR_W(ADDR_W), .LANES(LANES)) i_burst_cycle_ctrl (
        .clk(clk), .rst_n(rst_n), .pipe_en_n(pipe_en_n), .depth_en(depth_en),
        .depth_en_n(depth_en_n), .proc_strobe_n(proc_strobe_n),
        .ctrl_strobe_n(ctrl_strobe_n), .advance_n(advance_n),
        .interleave(interleave), .global_wr_n(global_wr_n),
        .byte_wr_n(byte_wr_n), .lane_wr_n(lane_wr_n), .out_en_n(out_en_n),
        .ext_addr(ext_addr), .mem_addr(mem_addr), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .mem_lane_we(mem_lane_we), .dq_drive(dq_drive)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    function automatic logic [ADDR_W-1:0] exp_addr();
        logic [1:0] lo;
        lo = interleave ? (m_start ^ m_step) : (m_start + m_step);
        return {m_hi, lo};
    endfunction

    task automatic check_all(input string tag);
        chk(tag, "mem_addr", int'(mem_addr), int'(exp_addr()));
        chk(tag, "mem_rd", int'(mem_rd), int'(m_kind == 1));
        chk(tag, "mem_wr", int'(mem_wr), int'(m_kind == 2));
        chk(tag, "mem_lane_we", int'(mem_lane_we), int'(m_lanes));
        chk("R11", "dq_drive", int'(dq_drive), int'(m_rdp && m_kind != 2 && !out_en_n));
    endtask

    // Advance model by one edge using the inputs currently applied.
    task automatic model_edge();
        logic sel;
        logic [LANES-1:0] wl;
        int nk;
        sel = !pipe_en_n && depth_en && !depth_en_n;
        if (!global_wr_n) wl = '1;
        else if (!byte_wr_n) wl = ~lane_wr_n;
        else wl = '0;
        m_rdp = (m_kind == 1);
        if (pipe_en_n && !ctrl_strobe_n) begin
            m_tag = "R2"; nk = 0; m_lanes = '0;
        end else if (!pipe_en_n && !proc_strobe_n) begin
            if (sel) begin
                m_tag = "R3"; nk = 1; m_lanes = '0;
                m_hi = ext_addr[ADDR_W-1:2]; m_start = ext_addr[1:0]; m_step = 0;
            end else begin
                m_tag = "R1"; nk = 0; m_lanes = '0;
            end
        end else if (!ctrl_strobe_n) begin
            if (sel) begin
                m_tag = "R5"; nk = (wl != 0) ? 2 : 1; m_lanes = wl;
                m_hi = ext_addr[ADDR_W-1:2]; m_start = ext_addr[1:0]; m_step = 0;
            end else begin
                m_tag = "R1"; nk = 0; m_lanes = '0;
            end
        end else if (m_kind == 0) begin
            m_tag = "R13"; nk = 0; m_lanes = '0;
        end else begin
            nk = (wl != 0) ? 2 : 1; m_lanes = wl;
            if (advance_n) m_tag = "R7";
            else begin m_tag = "R6"; m_step = m_step + 1'b1; end
        end
        m_kind = nk;
    endtask

    task automatic step(input string tag);
        model_edge();
        @(negedge clk);
        check_all(tag == "" ? m_tag : tag);
    endtask

    task automatic set_in(input logic pe, input logic de, input logic den,
                          input logic ps, input logic cs, input logic adv,
                          input logic gw, input logic bw, input logic [LANES-1:0] ln,
                          input logic [ADDR_W-1:0] a);
        pipe_en_n = pe; depth_en = de; depth_en_n = den;
        proc_strobe_n = ps; ctrl_strobe_n = cs; advance_n = adv;
        global_wr_n = gw; byte_wr_n = bw; lane_wr_n = ln; ext_addr = a;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        out_en_n = 1'b0;
        repeat (3) @(negedge clk);
        // reset state (R13)
        chk("R13", "reset mem_rd", int'(mem_rd), 0);
        chk("R13", "reset mem_wr", int'(mem_wr), 0);
        chk("R13", "reset dq_drive", int'(dq_drive), 0);
        chk("R13", "reset mem_addr", int'(mem_addr), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: idle with strobes high stays idle
        set_in(0,1,0, 1,1,0, 0,0,2'b00, 10'h155);
        step("R13");

        // R2: pipe enable high hides processor strobe
        set_in(1,1,0, 0,1,0, 1,1,2'b11, 10'h0AA);
        step("R2");
        chk("R2", "proc strobe ignored mem_rd", int'(mem_rd), 0);

        // R3: processor strobe with write inputs active still reads
        set_in(0,1,0, 0,1,1, 0,0,2'b00, 10'h2C5);
        step("R3");
        chk("R3", "pstart read", int'(mem_rd), 1);
        chk("R3", "pstart addr", int'(mem_addr), 'h2C5);

        // R4: following wait cycle with global write -> write same address
        set_in(0,1,0, 1,1,1, 0,1,2'b11, 10'h000);
        step("R4");
        chk("R4", "write after pstart", int'(mem_wr), 1);
        chk("R4", "write address", int'(mem_addr), 'h2C5);
        chk("R11", "drive off in write cycle", int'(dq_drive), 0);

        // R2: controller strobe with pipe enable high deselects
        set_in(1,1,0, 1,0,0, 1,1,2'b11, 10'h3FF);
        step("R2");
        chk("R2", "desel no write", int'(mem_wr), 0);

        // R1: each wrong enable combination with a strobe deselects
        for (int c = 0; c < 8; c++) begin
            logic pe, de, den;
            {pe, de, den} = c[2:0];
            set_in(0,1,0, 1,0,1, 1,1,2'b11, 10'h011);
            step("R5");
            set_in(pe,de,den, c[0] ? 1'b0 : 1'b1, c[0] ? 1'b1 : 1'b0, 1, 1,1,2'b11, 10'h222);
            step("R1");
        end

        // R8: lane decode via controller strobe
        set_in(0,1,0, 1,0,1, 1,0,2'b10, 10'h040);
        step("R8");
        chk("R8", "single lane strobe", int'(mem_lane_we), 'b01);
        set_in(0,1,0, 1,0,1, 1,0,2'b11, 10'h041);
        step("R8");
        chk("R8", "no lane -> read", int'(mem_rd), 1);
        set_in(0,1,0, 1,0,1, 1,1,2'b00, 10'h042);
        step("R8");
        chk("R8", "qualifier high -> read", int'(mem_wr), 0);
        set_in(0,1,0, 1,0,1, 0,1,2'b11, 10'h043);
        step("R8");
        chk("R8", "global all lanes", int'(mem_lane_we), 'b11);

        // R9: linear from start 1 -> 1,2,3,0,1
        interleave = 1'b0;
        set_in(0,1,0, 1,0,1, 1,1,2'b11, 10'h0F1);
        step("R5");
        for (int n = 1; n <= 4; n++) begin
            set_in(0,1,0, 1,1,0, 1,1,2'b11, 10'h000);
            step("R9");
            chk("R9", "linear offset", int'(mem_addr), int'({8'h3C, 2'((1 + n) % 4)}));
        end

        // R10: interleaved from start 1 -> 1,0,3,2
        interleave = 1'b1;
        set_in(0,1,0, 0,1,1, 1,1,2'b11, 10'h0F1);
        step("R3");
        for (int n = 1; n <= 4; n++) begin
            set_in(0,1,0, 1,1,0, 1,1,2'b11, 10'h000);
            step("R10");
            chk("R10", "interleaved offset", int'(mem_addr), int'({8'h3C, 2'(1 ^ (n % 4))}));
        end

        // R7: suspend holds address
        set_in(0,1,0, 1,1,1, 1,1,2'b11, 10'h000);
        step("R7");
        chk("R7", "suspend addr", int'(mem_addr), int'({8'h3C, 2'b01}));

        // R12: read then deselect: drive one more cycle, then off
        set_in(0,1,0, 1,0,1, 1,1,2'b11, 10'h100);
        step("R5");
        set_in(0,0,0, 1,0,1, 1,1,2'b11, 10'h100);
        step("R12");
        chk("R12", "drive after desel", int'(dq_drive), 1);
        set_in(0,1,0, 1,1,1, 1,1,2'b11, 10'h100);
        step("R12");
        chk("R12", "drive off next", int'(dq_drive), 0);

        // R11: output enable acts without clock
        set_in(0,1,0, 1,0,1, 1,1,2'b11, 10'h101);
        step("R5");
        set_in(0,1,0, 1,1,1, 1,1,2'b11, 10'h101);
        step("R7");
        out_en_n = 1'b1; #1;
        chk("R11", "oe high", int'(dq_drive), 0);
        out_en_n = 1'b0; #1;
        chk("R11", "oe low", int'(dq_drive), 1);
        @(negedge clk);
        check_all("R11");

        // Sweep over free inputs, biased toward bursts.
        for (int i = 0; i < 6000; i++) begin
            logic [15:0] r;
            r = 16'($urandom);
            set_in(r[0] & r[1], r[2] | r[3], r[4] & r[5],
                   r[6] | r[7], r[8] | r[9] | r[10], r[11],
                   r[12] | r[13], r[14], 2'($urandom), 10'($urandom));
            interleave = r[15];
            out_en_n = (i % 7 == 3);
            step("");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule